// File: doc/BRIEF.md
# Host Command Transfer Sequencer

This block runs one complete command exchange with a byte-wide command/response device, so that software does not have to poll the device itself. When started, it takes the command bytes from a local buffer and writes the response bytes into a local output buffer of a given capacity. It issues single-byte reads and writes on a simple request/acknowledge register bus. Waiting is paced by a microsecond tick input.

The exchange runs in a fixed order. The block first asks the device to become ready. It then sends the command in bursts, with each burst sized by the credit count the device reports. It checks that the device expects no more bytes and then starts execution. Once data is available it reads a fixed-size header, validates it, and reads the rest of the response in bursts. Every wait polls a status bit pattern at a fixed interval and has its own limit. The outcome is reported with a one-cycle completion pulse and a two-bit result code.

Top module: `cmd_xfer_seq`

## Requirements
- R1: A `start_i` pulse while idle raises `busy_o`. The first bus access is a write of 0x40 (ready request, bit 6) to the status register at offset 0x018. A `start_i` pulse while busy is ignored.
- R2: Status polling reads offset 0x018 once per `POLL_US` ticks. Success needs every required-set bit at 1 and every required-clear bit at 0. The ready wait needs bit 6 set. If the ready wait is still unmet after `ceil(TMO_READY_US/POLL_US)` reads, the block ends with code 1 (timeout).
- R3: The burst credit is read as two byte reads: low byte at 0x019, then high byte at 0x01A. While the credit is zero, the pair is re-read every `POLL_US` ticks. Reaching `TMO_BURST_US` ends with code 1.
- R4: Command bytes are written in order to the FIFO at 0x024. No more bytes are written than the last credit read allows, and exactly `cmd_len_i` bytes are written in total. A length of zero writes none.
- R5: After the command, the status must show valid (bit 7) = 1 and expect (bit 3) = 0 within `TMO_EXPECT_US`. Otherwise the block ends with code 2 (buffer too small).
- R6: The block then writes 0x20 (execute, bit 5) to the status register and waits for valid (bit 7) and data (bit 4) both set within `TMO_DATA_US`. Otherwise it ends with code 1.
- R7: Exactly 10 header bytes are read from the FIFO. If the big-endian 16-bit tag in bytes 0 and 1 differs from `RSP_TAG`, the block ends with code 3 (unsupported).
- R8: The big-endian 32-bit size in bytes 2 to 5 is compared with `rsp_cap_i`. If the size is larger, the block ends with code 2 after the 10 header bytes.
- R9: The remaining bytes are read in bursts until exactly the size has been read, with no further FIFO read. Each byte n is written to output index n. On success the code is 0 and `rsp_len_o` equals the size.
- R10: Every exchange, including a failed one, ends with a write of 0x40 to the status register as its last bus access before `done_o`.
- R11: `done_o` is high for exactly one cycle. `status_o` and `rsp_len_o` stay constant until the next accepted start. `rsp_len_o` is 0 after any failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| start_i | input | 1 | Start an exchange (taken only while idle) |
| cmd_len_i | input | LEN_W | Command length in bytes, sampled at start |
| rsp_cap_i | input | LEN_W | Output buffer capacity in bytes, sampled at start |
| cmd_rd_addr_o | output | LEN_W | Command buffer read index |
| cmd_rd_data_i | input | 8 | Command buffer byte at `cmd_rd_addr_o`, combinational |
| rsp_wr_o | output | 1 | Output buffer write strobe |
| rsp_wr_addr_o | output | LEN_W | Output buffer write index |
| rsp_wr_data_o | output | 8 | Output buffer write byte |
| bus_req_o | output | 1 | Register access request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register offset |
| bus_wdata_o | output | 8 | Write byte |
| bus_ack_i | input | 1 | One-cycle acknowledge; read data valid with it |
| bus_rdata_i | input | 8 | Read byte |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 timeout, 2 buffer too small, 3 unsupported |
| rsp_len_o | output | LEN_W | Response length on success, else 0 |

## Verification
The assertions assume a bus partner that returns `bus_ack_i` for one cycle per request and never acknowledges while no request is pending. They also assume a command buffer that answers in the same cycle, and a capacity of at least the 10-byte header. The bench's device model only acknowledges a pending request and drops the acknowledge in the following cycle. Random response sizes and capacities are drawn from 10 upward, and credit values stay non-zero except for the deliberate stalls. Its polling delays and zero-credit counts stay inside the shortened limits, except in the directed timeout cases.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_SMALL   = 2'd2,
    ST_UNSUP   = 2'd3
  } xfer_status_e;

  typedef enum logic [1:0] {PH_SEND, PH_HDR, PH_BODY} burst_ph_e;

  localparam logic [11:0] REG_STS   = 12'h018;
  localparam logic [11:0] REG_BC_LO = 12'h019;
  localparam logic [11:0] REG_BC_HI = 12'h01A;
  localparam logic [11:0] REG_FIFO  = 12'h024;

  localparam logic [7:0] M_VALID  = 8'h80;
  localparam logic [7:0] M_READY  = 8'h40;
  localparam logic [7:0] M_GO     = 8'h20;
  localparam logic [7:0] M_DATA   = 8'h10;
  localparam logic [7:0] M_EXPECT = 8'h08;

  localparam int HDR_BYTES = 10;
endpackage

// File: rtl/cxs_poll_timer.sv
module cxs_poll_timer #(
  parameter int POLL_US = 30,
  parameter int CNT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             iv_done_o,
  output logic [CNT_W-1:0] elapsed_o
);
  localparam int IV_W = $clog2(POLL_US + 1);

  logic [IV_W-1:0] iv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q      <= '0;
      iv_done_o <= 1'b0;
      elapsed_o <= '0;
    end else begin
      iv_done_o <= 1'b0;
      if (clr_i) begin
        iv_q      <= '0;
        elapsed_o <= '0;
      end else if (run_i && tick_i) begin
        elapsed_o <= elapsed_o + 1'b1;
        if (iv_q == IV_W'(POLL_US - 1)) begin
          iv_q      <= '0;
          iv_done_o <= 1'b1;
        end else begin
          iv_q <= iv_q + 1'b1;
        end
      end
    end
  end

  // R2: an interval only completes after a counted tick
  p_iv_after_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iv_done_o |-> $past(run_i && tick_i && !clr_i));
endmodule

// File: rtl/cxs_bus_port.sv
module cxs_bus_port #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [7:0]        bus_rdata_i
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        bus_req_o   <= 1'b1;
        bus_we_o    <= we_i;
        bus_addr_o  <= addr_i;
        bus_wdata_o <= wdata_i;
      end else if (bus_req_o && bus_ack_i) begin
        bus_req_o <= 1'b0;
        rdata_o   <= bus_rdata_i;
        done_o    <= 1'b1;
      end
    end
  end

  // R4: request fields hold until acknowledged
  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o)));
  // R10: one access in flight at a time
  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (!bus_req_o && !done_o));
endmodule

// File: rtl/cxs_hdr_capture.sv
module cxs_hdr_capture (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  idx_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] tag_o,
  output logic [31:0] size_o
);
  localparam int FIELD_BYTES = 6;

  logic [7:0] b_q [FIELD_BYTES];

  for (genvar g = 0; g < FIELD_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          b_q[g] <= '0;
      else if (wr_i && idx_i == 4'(g))      b_q[g] <= byte_i;
    end
  end

  assign tag_o  = {b_q[0], b_q[1]};
  assign size_o = {b_q[2], b_q[3], b_q[4], b_q[5]};
endmodule

// File: rtl/cmd_xfer_seq.sv
module cmd_xfer_seq
  import cxs_pkg::*;
#(
  parameter int          LEN_W         = 16,
  parameter int          ADDR_W        = 12,
  parameter int          CNT_W         = 32,
  parameter int          POLL_US       = 30,
  parameter int          TMO_READY_US  = 750000,
  parameter int          TMO_BURST_US  = 750000,
  parameter int          TMO_EXPECT_US = 750000,
  parameter int          TMO_DATA_US   = 2000000,
  parameter logic [15:0] RSP_TAG       = 16'h00C4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              us_tick_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [LEN_W-1:0]  rsp_cap_i,
  output logic [LEN_W-1:0]  cmd_rd_addr_o,
  input  logic [7:0]        cmd_rd_data_i,
  output logic              rsp_wr_o,
  output logic [LEN_W-1:0]  rsp_wr_addr_o,
  output logic [7:0]        rsp_wr_data_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [7:0]        bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [LEN_W-1:0]  rsp_len_o
);
  localparam logic [CNT_W-1:0] LIM_READY  = CNT_W'(TMO_READY_US);
  localparam logic [CNT_W-1:0] LIM_BURST  = CNT_W'(TMO_BURST_US);
  localparam logic [CNT_W-1:0] LIM_EXPECT = CNT_W'(TMO_EXPECT_US);
  localparam logic [CNT_W-1:0] LIM_DATA   = CNT_W'(TMO_DATA_US);
  localparam logic [LEN_W-1:0] HDR_LEN    = LEN_W'(HDR_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_RDYW, S_CMD, S_PRD, S_PWAIT, S_BLO, S_BHI, S_BWAIT,
    S_SEND, S_GOW, S_HDR, S_CHK, S_BODY, S_FIN
  } st_e;

  st_e              state_q, poll_next_q;
  burst_ph_e        ph_q;
  xfer_status_e     status_q, poll_fail_q;
  logic [LEN_W-1:0] len_q, cap_q, idx_q, rsp_len_q;
  logic [15:0]      bc_q;
  logic [7:0]       bc_lo_q, poll_set_q, poll_clr_q;
  logic [CNT_W-1:0] poll_lim_q;
  logic             iss_q, tmr_clr_q, done_q;

  logic              acc_need, acc_go, acc_we, acc_done;
  logic [ADDR_W-1:0] acc_addr;
  logic [7:0]        acc_wd, acc_rdata;
  logic              iv_done;
  logic [CNT_W-1:0]  elapsed;
  logic [15:0]       hdr_tag, bc_val;
  logic [31:0]       hdr_size;
  logic              tmr_run, poll_hit;

  // access descriptor per state
  always_comb begin
    acc_need = 1'b0;
    acc_we   = 1'b0;
    acc_addr = ADDR_W'(REG_STS);
    acc_wd   = '0;
    unique case (state_q)
      S_RDYW, S_FIN: begin acc_need = 1'b1; acc_we = 1'b1; acc_wd = M_READY; end
      S_GOW:         begin acc_need = 1'b1; acc_we = 1'b1; acc_wd = M_GO; end
      S_PRD:         acc_need = 1'b1;
      S_BLO:         begin acc_need = 1'b1; acc_addr = ADDR_W'(REG_BC_LO); end
      S_BHI:         begin acc_need = 1'b1; acc_addr = ADDR_W'(REG_BC_HI); end
      S_SEND: begin
        acc_need = (bc_q != '0) && (idx_q != len_q);
        acc_we   = 1'b1;
        acc_addr = ADDR_W'(REG_FIFO);
        acc_wd   = cmd_rd_data_i;
      end
      S_HDR: begin
        acc_need = (bc_q != '0) && (idx_q != HDR_LEN);
        acc_addr = ADDR_W'(REG_FIFO);
      end
      S_BODY: begin
        acc_need = (bc_q != '0) && (32'(idx_q) != hdr_size);
        acc_addr = ADDR_W'(REG_FIFO);
      end
      default: ;
    endcase
  end

  assign acc_go   = acc_need && !iss_q;
  assign tmr_run  = (state_q == S_PWAIT || state_q == S_BWAIT) && !iv_done;
  assign bc_val   = {acc_rdata, bc_lo_q};
  assign poll_hit = ((acc_rdata & poll_set_q) == poll_set_q) && ((acc_rdata & poll_clr_q) == '0);

  cxs_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni,
    .go_i(acc_go), .we_i(acc_we), .addr_i(acc_addr), .wdata_i(acc_wd),
    .done_o(acc_done), .rdata_o(acc_rdata),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o, .bus_ack_i, .bus_rdata_i
  );

  cxs_poll_timer #(.POLL_US(POLL_US), .CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr_q), .run_i(tmr_run), .tick_i(us_tick_i),
    .iv_done_o(iv_done), .elapsed_o(elapsed)
  );

  cxs_hdr_capture u_hdr (
    .clk_i, .rst_ni,
    .wr_i(acc_done && state_q == S_HDR), .idx_i(idx_q[3:0]), .byte_i(acc_rdata),
    .tag_o(hdr_tag), .size_o(hdr_size)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_IDLE;
      poll_next_q   <= S_IDLE;
      ph_q          <= PH_SEND;
      status_q      <= ST_OK;
      poll_fail_q   <= ST_OK;
      len_q         <= '0;
      cap_q         <= '0;
      idx_q         <= '0;
      rsp_len_q     <= '0;
      bc_q          <= '0;
      bc_lo_q       <= '0;
      poll_set_q    <= '0;
      poll_clr_q    <= '0;
      poll_lim_q    <= '0;
      iss_q         <= 1'b0;
      tmr_clr_q     <= 1'b0;
      done_q        <= 1'b0;
      rsp_wr_o      <= 1'b0;
      rsp_wr_addr_o <= '0;
      rsp_wr_data_o <= '0;
    end else begin
      done_q    <= 1'b0;
      tmr_clr_q <= 1'b0;
      rsp_wr_o  <= 1'b0;
      if (acc_go)        iss_q <= 1'b1;
      else if (acc_done) iss_q <= 1'b0;

      unique case (state_q)
        S_IDLE: if (start_i) begin
          len_q     <= cmd_len_i;
          cap_q     <= rsp_cap_i;
          idx_q     <= '0;
          bc_q      <= '0;
          status_q  <= ST_OK;
          rsp_len_q <= '0;
          state_q   <= S_RDYW;
        end
        S_RDYW: if (acc_done) begin
          poll_set_q  <= M_READY;
          poll_clr_q  <= '0;
          poll_lim_q  <= LIM_READY;
          poll_fail_q <= ST_TIMEOUT;
          poll_next_q <= S_CMD;
          tmr_clr_q   <= 1'b1;
          state_q     <= S_PRD;
        end
        S_CMD: begin
          tmr_clr_q <= 1'b1;
          if (idx_q == len_q) begin
            poll_set_q  <= M_VALID;
            poll_clr_q  <= M_EXPECT;
            poll_lim_q  <= LIM_EXPECT;
            poll_fail_q <= ST_SMALL;
            poll_next_q <= S_GOW;
            state_q     <= S_PRD;
          end else begin
            ph_q    <= PH_SEND;
            state_q <= S_BLO;
          end
        end
        S_PRD: if (acc_done) state_q <= poll_hit ? poll_next_q : S_PWAIT;
        S_PWAIT: if (iv_done) begin
          if (elapsed >= poll_lim_q) begin
            status_q <= poll_fail_q;
            state_q  <= S_FIN;
          end else begin
            state_q <= S_PRD;
          end
        end
        S_BLO: if (acc_done) begin
          bc_lo_q <= acc_rdata;
          state_q <= S_BHI;
        end
        S_BHI: if (acc_done) begin
          if (bc_val != '0) begin
            bc_q <= bc_val;
            unique case (ph_q)
              PH_SEND: state_q <= S_SEND;
              PH_HDR:  state_q <= S_HDR;
              default: state_q <= S_BODY;
            endcase
          end else begin
            state_q <= S_BWAIT;
          end
        end
        S_BWAIT: if (iv_done) begin
          if (elapsed >= LIM_BURST) begin
            status_q <= ST_TIMEOUT;
            state_q  <= S_FIN;
          end else begin
            state_q <= S_BLO;
          end
        end
        S_SEND: begin
          if (acc_done) begin
            idx_q <= idx_q + 1'b1;
            bc_q  <= bc_q - 1'b1;
          end else if (!iss_q && !acc_need) begin
            state_q <= S_CMD;
          end
        end
        S_GOW: if (acc_done) begin
          idx_q       <= '0;
          bc_q        <= '0;
          poll_set_q  <= M_VALID | M_DATA;
          poll_clr_q  <= '0;
          poll_lim_q  <= LIM_DATA;
          poll_fail_q <= ST_TIMEOUT;
          poll_next_q <= S_HDR;
          tmr_clr_q   <= 1'b1;
          state_q     <= S_PRD;
        end
        S_HDR, S_BODY: begin
          if (acc_done) begin
            rsp_wr_o      <= 1'b1;
            rsp_wr_addr_o <= idx_q;
            rsp_wr_data_o <= acc_rdata;
            idx_q         <= idx_q + 1'b1;
            bc_q          <= bc_q - 1'b1;
          end else if (!iss_q && !acc_need) begin
            if (state_q == S_HDR && idx_q == HDR_LEN) begin
              state_q <= S_CHK;
            end else if (state_q == S_BODY && 32'(idx_q) == hdr_size) begin
              rsp_len_q <= idx_q;
              state_q   <= S_FIN;
            end else begin
              ph_q      <= (state_q == S_HDR) ? PH_HDR : PH_BODY;
              tmr_clr_q <= 1'b1;
              state_q   <= S_BLO;
            end
          end
        end
        S_CHK: begin
          if (hdr_tag != RSP_TAG) begin
            status_q <= ST_UNSUP;
            state_q  <= S_FIN;
          end else if (hdr_size > 32'(cap_q)) begin
            status_q <= ST_SMALL;
            state_q  <= S_FIN;
          end else if (hdr_size <= 32'(idx_q)) begin
            rsp_len_q <= hdr_size[LEN_W-1:0];
            state_q   <= S_FIN;
          end else begin
            state_q <= S_BODY;
          end
        end
        S_FIN: if (acc_done) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_rd_addr_o = idx_q;
  assign busy_o        = (state_q != S_IDLE);
  assign done_o        = done_q;
  assign status_o      = status_q;
  assign rsp_len_o     = rsp_len_q;

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_status_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(status_o) && $stable(rsp_len_o)));
  p_fifo_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(REG_FIFO)) |-> (idx_q < len_q));
  p_body_tag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BODY) |-> (hdr_tag == RSP_TAG));
  p_body_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BODY) |-> (hdr_size <= 32'(cap_q)));
  p_fin_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_we_o && bus_addr_o == ADDR_W'(REG_STS) && bus_wdata_o == M_READY));
endmodule

// File: tb/sim_cmd_xfer_seq.sv
module sim_cmd_xfer_seq;
  localparam int LEN_W = 16;
  localparam int POLL  = 3;
  localparam int T_RDY = 30;
  localparam int T_BC  = 30;
  localparam int T_EXP = 30;
  localparam int T_DAT = 60;
  localparam int N_POLL_RDY = (T_RDY + POLL - 1) / POLL;
  localparam int N_POLL_BC  = (T_BC + POLL - 1) / POLL;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [LEN_W-1:0] cmd_len = '0, rsp_cap = '0;
  logic [LEN_W-1:0] cmd_rd_addr, rsp_wr_addr, rsp_len;
  logic [7:0] cmd_rd_data, rsp_wr_data, bus_wdata;
  logic rsp_wr, bus_req, bus_we, busy, done;
  logic [11:0] bus_addr;
  logic bus_ack = 1'b0;
  logic [7:0] bus_rdata = '0;
  logic [1:0] status;

  logic [7:0] cmd_mem [256];
  logic [7:0] rsp_mem [256];
  logic [7:0] out_mem [256];
  logic [7:0] rx_mem  [256];

  int dev_rdy_delay, dev_zero_left, dev_burst, dev_sts_reads, dev_sts_total;
  int dev_rx, dev_tx, dev_since_bc, dev_bc_val, dev_cur_bc, dev_nacc;
  bit dev_expect_stuck, dev_data_never, dev_go, dev_viol;
  logic [11:0] first_addr, last_addr;
  logic [7:0]  first_wd, last_wd;
  bit first_we, last_we;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign cmd_rd_data = cmd_mem[cmd_rd_addr[7:0]];

  cmd_xfer_seq #(
    .LEN_W(LEN_W), .POLL_US(POLL), .TMO_READY_US(T_RDY), .TMO_BURST_US(T_BC),
    .TMO_EXPECT_US(T_EXP), .TMO_DATA_US(T_DAT)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .start_i(start),
    .cmd_len_i(cmd_len), .rsp_cap_i(rsp_cap),
    .cmd_rd_addr_o(cmd_rd_addr), .cmd_rd_data_i(cmd_rd_data),
    .rsp_wr_o(rsp_wr), .rsp_wr_addr_o(rsp_wr_addr), .rsp_wr_data_o(rsp_wr_data),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .busy_o(busy), .done_o(done), .status_o(status), .rsp_len_o(rsp_len)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  task automatic dev_access();
    if (dev_nacc == 0) begin
      first_addr = bus_addr; first_we = bus_we; first_wd = bus_wdata;
    end
    dev_nacc++;
    last_addr = bus_addr; last_we = bus_we; last_wd = bus_wdata;
    if (bus_we) begin
      if (bus_addr == 12'h018) begin
        if (bus_wdata[6]) begin dev_sts_reads = 0; dev_go = 1'b0; end
        if (bus_wdata[5]) dev_go = 1'b1;
      end else if (bus_addr == 12'h024) begin
        rx_mem[dev_rx[7:0]] = bus_wdata;
        dev_rx++;
        dev_since_bc++;
        if (dev_since_bc > dev_bc_val) dev_viol = 1'b1;
      end
    end else begin
      case (bus_addr)
        12'h018: begin
          bus_rdata = 8'h80;
          if (dev_sts_reads >= dev_rdy_delay) bus_rdata[6] = 1'b1;
          if (dev_go && !dev_data_never)      bus_rdata[4] = 1'b1;
          if (dev_expect_stuck)               bus_rdata[3] = 1'b1;
          dev_sts_reads++;
          dev_sts_total++;
        end
        12'h019: begin
          dev_cur_bc = (dev_zero_left > 0) ? 0 : dev_burst;
          bus_rdata  = dev_cur_bc[7:0];
        end
        12'h01A: begin
          bus_rdata = dev_cur_bc[15:8];
          if (dev_zero_left > 0) dev_zero_left--;
          dev_since_bc = 0;
          dev_bc_val   = dev_cur_bc;
        end
        12'h024: begin
          bus_rdata = rsp_mem[dev_tx[7:0]];
          dev_tx++;
          dev_since_bc++;
          if (dev_since_bc > dev_bc_val) dev_viol = 1'b1;
        end
        default: bus_rdata = 8'h00;
      endcase
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      dev_access();
      bus_ack = 1'b1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rsp_wr) out_mem[rsp_wr_addr[7:0]] = rsp_wr_data;
  end

  function automatic int exp_status(int rdy_d, int zero, bit stuck, bit dnever,
                                    int tag, int size, int cap);
    if (rdy_d >= N_POLL_RDY) return 1;
    if (zero >= N_POLL_BC)   return 1;
    if (stuck)               return 2;
    if (dnever)              return 1;
    if (tag != 16'h00C4)     return 3;
    if (size > cap)          return 2;
    return 0;
  endfunction

  task automatic run_xfer(input int len, input int size, input int cap, input int tag,
                          input int burst, input int zero, input int rdy_d,
                          input bit stuck, input bit dnever, input bit mid_start,
                          input string name);
    int es, exp_rx, exp_tx, cyc;
    bit ok;
    dev_rdy_delay = rdy_d; dev_zero_left = zero; dev_burst = burst;
    dev_expect_stuck = stuck; dev_data_never = dnever;
    dev_sts_reads = 0; dev_sts_total = 0; dev_rx = 0; dev_tx = 0;
    dev_since_bc = 0; dev_bc_val = 0; dev_nacc = 0; dev_go = 1'b0; dev_viol = 1'b0;
    for (int i = 0; i < 256; i++) begin
      cmd_mem[i] = 8'($urandom);
      rsp_mem[i] = 8'($urandom);
      out_mem[i] = 8'h00;
    end
    rsp_mem[0] = 8'(tag >> 8);  rsp_mem[1] = 8'(tag);
    rsp_mem[2] = 8'(size >> 24); rsp_mem[3] = 8'(size >> 16);
    rsp_mem[4] = 8'(size >> 8);  rsp_mem[5] = 8'(size);
    es = exp_status(rdy_d, (len > 0 || !stuck) ? zero : 0, stuck, dnever, tag, size, cap);
    exp_rx = (rdy_d >= N_POLL_RDY || zero >= N_POLL_BC) ? 0 : len;
    exp_tx = (es == 0) ? size : ((es == 3 || (es == 2 && !stuck)) ? 10 : 0);

    @(negedge clk);
    cmd_len = LEN_W'(len); rsp_cap = LEN_W'(cap); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R1 busy after start ", name}, busy, 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (mid_start && cyc == 20) begin
        chk(busy == 1'b1, "R1 busy at second start", busy, 1);
        start = 1'b1; cmd_len = 1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, {"R11 done seen ", name}, done, 1);
    chk(int'(status) == es, {"R2-status ", name}, status, es);
    chk(first_we && first_addr == 12'h018 && first_wd == 8'h40, {"R1 first access ", name},
        first_wd, 8'h40);
    chk(last_we && last_addr == 12'h018 && last_wd == 8'h40, {"R10 last access ", name},
        last_wd, 8'h40);
    chk(dev_rx == exp_rx, {"R4 bytes sent ", name}, dev_rx, exp_rx);
    ok = 1'b1;
    for (int i = 0; i < exp_rx; i++) if (rx_mem[i] != cmd_mem[i]) ok = 1'b0;
    chk(ok, {"R4 command order ", name}, ok, 1);
    chk(!dev_viol, {"R4 R9 credit respected ", name}, dev_viol, 0);
    chk(dev_tx == exp_tx, {"R7 R9 bytes read ", name}, dev_tx, exp_tx);
    chk(int'(rsp_len) == ((es == 0) ? size : 0), {"R9 R11 rsp_len ", name}, rsp_len,
        (es == 0) ? size : 0);
    if (es == 0) begin
      ok = 1'b1;
      for (int i = 0; i < size; i++) if (out_mem[i] != rsp_mem[i]) ok = 1'b0;
      chk(ok, {"R9 output content ", name}, ok, 1);
    end
    @(negedge clk);
    chk(done == 1'b0, {"R11 done one cycle ", name}, done, 0);
    repeat (5) @(negedge clk);
    chk(int'(status) == es && busy == 1'b0, {"R11 status held ", name}, status, es);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && status == 0 && bus_req == 0 && rsp_len == 0,
        "R11 reset state", {busy, done, status, bus_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_xfer(12, 20, 40, 16'h00C4, 5, 0, 0, 0, 0, 0, "basic");
    run_xfer(8, 14, 20, 16'h00C4, 3, 0, 0, 0, 0, 1, "restart ignored R1");
    run_xfer(5, 12, 30, 16'h00C4, 4, 0, 40, 0, 0, 0, "ready timeout R2");
    chk(dev_sts_total == N_POLL_RDY, "R2 ready poll count", dev_sts_total, N_POLL_RDY);
    run_xfer(6, 12, 30, 16'h00C4, 4, 2, 3, 0, 0, 0, "late ready and credit R2 R3");
    run_xfer(6, 12, 30, 16'h00C4, 4, 1000, 0, 0, 0, 0, "credit timeout R3");
    run_xfer(20, 30, 40, 16'h00C4, 300, 0, 0, 0, 0, 0, "wide credit R3");
    run_xfer(0, 16, 40, 16'h00C4, 2, 0, 0, 0, 0, 0, "empty command R4");
    run_xfer(9, 12, 30, 16'h00C4, 4, 0, 0, 1, 0, 0, "expect stuck R5");
    run_xfer(9, 12, 30, 16'h00C4, 4, 0, 0, 0, 1, 0, "no data R6");
    run_xfer(9, 20, 30, 16'h00C1, 4, 0, 0, 0, 0, 0, "bad tag R7");
    run_xfer(9, 31, 30, 16'h00C4, 7, 0, 0, 0, 0, 0, "too large R8");
    run_xfer(9, 30, 30, 16'h00C4, 7, 0, 0, 0, 0, 0, "size equals capacity R8");
    run_xfer(4, 10, 10, 16'h00C4, 3, 0, 0, 0, 0, 0, "header only R9");
    run_xfer(4, 11, 20, 16'h00C4, 1, 0, 0, 0, 0, 0, "single credit R9");

    for (int t = 0; t < 30; t++) begin
      int len, size, cap, tag, burst;
      len   = int'($urandom_range(0, 30));
      size  = int'($urandom_range(10, 40));
      cap   = int'($urandom_range(10, 45));
      tag   = ($urandom_range(0, 9) == 0) ? 16'h0100 : 16'h00C4;
      burst = ($urandom_range(0, 5) == 0) ? 300 : int'($urandom_range(1, 8));
      run_xfer(len, size, cap, tag, burst, int'($urandom_range(0, 3)),
               int'($urandom_range(0, 4)), 0, 0, 0, "random R9");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule